// File: doc/BRIEF.md
# Triggered Capture Window Controller

This controller sits between a sampling front end and a buffer FIFO that receives one converter word on every clock. The converter and the FIFO write port run from the same clock, so each edge stores the sample produced on the edge before it. The controller only decides when those writes are allowed. It drives the FIFO's active-low write enable. That enable goes low for a fixed capture window, which opens on the rising edge of an external sync input. It goes high again once the window has counted a set number of timing ticks.

On the read side, the controller watches the FIFO's almost-empty flag. The flag is high when more than one block minus one word is stored. When the flag is high, the controller runs a read burst of exactly one block of 16-bit words (14-bit samples, zero-extended) toward a consumer. After the burst it raises a one-cycle block-ready pulse. It then holds off further reads until the consumer reports that it has finished processing. A consumer acknowledge that arrives while the flag is still high starts the next burst at once.

Top module: `capture_window_ctrl`

## Requirements
- R1: After reset the write enable output is high, and window status, read enable, burst request and block-ready are all low.
- R2: The write enable is active-low. It is high in every cycle in which the capture window is closed, and window status is high exactly while it is low.
- R3: A low-to-high transition on sync, sampled while the window is closed, opens the window on that same clock edge.
- R4: A sync rising edge that arrives while the window is open is ignored, including on the closing cycle. A sync level held high across a window close does not reopen the window.
- R5: The window closes on the edge that samples its WIN_TICKS-th tick pulse, counted from the opening edge. Ticks seen while the window is closed have no effect.
- R6: When no burst is active or awaiting acknowledge, a high almost-empty flag starts a burst on the next edge. The burst request output pulses for one cycle, together with the first read strobe.
- R7: Each burst asserts read enable for exactly BURST_LEN consecutive cycles.
- R8: Block-ready is a one-cycle pulse in the cycle that follows the last read strobe of a burst.
- R9: After a burst, no further read strobe occurs until consumer-done is sampled high. A consumer-done seen during a burst has no effect.
- R10: A consumer-done sampled while the flag is high starts the next burst on that edge, with no idle cycle. A consumer-done sampled while the flag is low re-arms the controller, and it then waits for the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample and control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_i | input | 1 | External capture trigger, rising edge |
| tick_i | input | 1 | Window timing tick, one cycle per tick |
| ae_flag_i | input | 1 | FIFO almost-empty flag, high when a block is stored |
| cons_done_i | input | 1 | Consumer has finished processing the block |
| wr_en_n_o | output | 1 | FIFO write enable, active low |
| window_o | output | 1 | Capture window open |
| burst_req_o | output | 1 | One-cycle pulse marking the start of a burst |
| rd_en_o | output | 1 | FIFO read strobe, one word per cycle |
| blk_rdy_o | output | 1 | One-cycle pulse after a complete block |

## Verification
A wrong window count shows up as write enable going high one or more tick periods early or late, so it is visible on the first capture round. A mis-sequenced drain state shows up within one block. The read strobe runs one word too long or too short, block-ready lands on the wrong cycle, or reads resume without an acknowledge. A lost priority path shows up as a dead cycle between acknowledge and the next read strobe, on the very cycle after the acknowledge.

// File: rtl/cwc_pkg.sv
package cwc_pkg;

  typedef enum logic {
    WS_IDLE    = 1'b0,
    WS_CAPTURE = 1'b1
  } win_st_t;

  typedef enum logic [1:0] {
    DR_ARMED = 2'd0,
    DR_BURST = 2'd1,
    DR_WAIT  = 2'd2
  } drain_st_t;

  // True when a zero-based count sits on the final slot of a run of len
  function automatic logic at_final(input int unsigned cnt, input int unsigned len);
    return cnt == len - 1;
  endfunction

  // Next value of a zero-based count that wraps after len slots
  function automatic int unsigned step_count(input int unsigned cnt, input int unsigned len);
    return (cnt == len - 1) ? 0 : cnt + 1;
  endfunction

endpackage

// File: rtl/cwc_edge.sv
module cwc_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic rise_o
);

  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;

endmodule

// File: rtl/cwc_window.sv
module cwc_window
  import cwc_pkg::*;
#(
  parameter int unsigned WIN_TICKS = 22000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rise_i,
  input  logic tick_i,
  output logic open_o
);

  localparam int unsigned CW = (WIN_TICKS > 2) ? $clog2(WIN_TICKS) : 1;

  win_st_t       st_q;
  logic [CW-1:0] cnt_q;
  logic          last_tick;
  logic          start_win;

  assign last_tick = tick_i & at_final(32'(cnt_q), WIN_TICKS);
  assign start_win = (st_q == WS_IDLE) & rise_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= WS_IDLE;
      cnt_q <= '0;
    end else begin
      case (st_q)
        WS_IDLE: begin
          if (start_win) begin
            st_q  <= WS_CAPTURE;
            cnt_q <= '0;
          end
        end
        WS_CAPTURE: begin
          if (tick_i) begin
            cnt_q <= CW'(step_count(32'(cnt_q), WIN_TICKS));
            if (last_tick) st_q <= WS_IDLE;
          end
        end
        default: st_q <= WS_IDLE;
      endcase
    end
  end

  assign open_o = (st_q == WS_CAPTURE);

  // R3: a sync edge while closed opens the window
  a_r3_open_on_sync: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == WS_IDLE && rise_i) |=> open_o);

  // R4: sync edges while open never disturb the running window
  a_r4_sync_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == WS_CAPTURE && !last_tick) |=> (open_o && $stable(cnt_q) || $past(tick_i)));

  // R5: the final tick closes the window
  a_r5_close_on_count: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == WS_CAPTURE && tick_i && cnt_q == CW'(WIN_TICKS - 1)) |=> !open_o);

  // R5: the count never passes the window length
  a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cnt_q) < WIN_TICKS);

endmodule

// File: rtl/cwc_drain.sv
module cwc_drain
  import cwc_pkg::*;
#(
  parameter int unsigned BURST_LEN = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ae_flag_i,
  input  logic cons_done_i,
  output logic burst_req_o,
  output logic rd_en_o,
  output logic blk_rdy_o
);

  localparam int unsigned BW = (BURST_LEN > 2) ? $clog2(BURST_LEN) : 1;

  drain_st_t     st_q;
  logic [BW-1:0] cnt_q;
  logic          rdy_q;
  logic          last_rd;
  logic          chain_go;

  assign last_rd  = (st_q == DR_BURST) & at_final(32'(cnt_q), BURST_LEN);
  assign chain_go = (st_q == DR_WAIT) & cons_done_i & ae_flag_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= DR_ARMED;
      cnt_q <= '0;
      rdy_q <= 1'b0;
    end else begin
      rdy_q <= last_rd;
      case (st_q)
        DR_ARMED: begin
          if (ae_flag_i) begin
            st_q  <= DR_BURST;
            cnt_q <= '0;
          end
        end
        DR_BURST: begin
          cnt_q <= BW'(step_count(32'(cnt_q), BURST_LEN));
          if (last_rd) st_q <= DR_WAIT;
        end
        DR_WAIT: begin
          if (chain_go) begin
            st_q  <= DR_BURST;
            cnt_q <= '0;
          end else if (cons_done_i) begin
            st_q <= DR_ARMED;
          end
        end
        default: st_q <= DR_ARMED;
      endcase
    end
  end

  assign rd_en_o     = (st_q == DR_BURST);
  assign burst_req_o = rd_en_o & (cnt_q == '0);
  assign blk_rdy_o   = rdy_q;

  // R6: a high flag while armed starts a burst
  a_r6_start_burst: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == DR_ARMED && ae_flag_i) |=> burst_req_o);

  // R7: reads continue until the final word of the block
  a_r7_reads_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_o && !last_rd) |=> rd_en_o);

  // R8: block-ready follows the last read
  a_r8_ready_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    last_rd |=> (blk_rdy_o && !rd_en_o));

  // R8: block-ready is a single-cycle pulse
  a_r8_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    blk_rdy_o |=> !blk_rdy_o);

  // R9: no reads while waiting for the consumer
  a_r9_hold_for_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == DR_WAIT && !cons_done_i) |=> !rd_en_o);

  // R10: acknowledge with flag high chains straight into a burst
  a_r10_chain: assert property (@(posedge clk) disable iff (!rst_n)
    chain_go |=> burst_req_o);

endmodule

// File: rtl/capture_window_ctrl.sv
module capture_window_ctrl #(
  parameter int unsigned WIN_TICKS = 22000,
  parameter int unsigned BURST_LEN = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_i,
  input  logic tick_i,
  input  logic ae_flag_i,
  input  logic cons_done_i,
  output logic wr_en_n_o,
  output logic window_o,
  output logic burst_req_o,
  output logic rd_en_o,
  output logic blk_rdy_o
);

  logic sync_rise;
  logic win_open;

  cwc_edge u_sync_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_i  (sync_i),
    .rise_o (sync_rise)
  );

  cwc_window #(
    .WIN_TICKS (WIN_TICKS)
  ) u_window (
    .clk    (clk),
    .rst_n  (rst_n),
    .rise_i (sync_rise),
    .tick_i (tick_i),
    .open_o (win_open)
  );

  cwc_drain #(
    .BURST_LEN (BURST_LEN)
  ) u_drain (
    .clk         (clk),
    .rst_n       (rst_n),
    .ae_flag_i   (ae_flag_i),
    .cons_done_i (cons_done_i),
    .burst_req_o (burst_req_o),
    .rd_en_o     (rd_en_o),
    .blk_rdy_o   (blk_rdy_o)
  );

  assign wr_en_n_o = ~win_open;
  assign window_o  = win_open;

  // R1: outputs idle while reset is held
  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_n |-> (wr_en_n_o && !rd_en_o && !blk_rdy_o));

  // R2: a sync edge never opens writes without the window
  a_r2_wen_window: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_en_n_o) |-> $past(sync_i) || sync_i);

endmodule

// File: tb/capture_window_ctrl_test.sv
`timescale 1ns/1ps
module capture_window_ctrl_test;

  localparam int unsigned WT = 4;
  localparam int unsigned BL = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync_i = 1'b0, tick_i = 1'b0, ae_flag_i = 1'b0, cons_done_i = 1'b0;
  logic wr_en_n_o, window_o, burst_req_o, rd_en_o, blk_rdy_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  capture_window_ctrl #(.WIN_TICKS(WT), .BURST_LEN(BL)) uut (
    .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .tick_i(tick_i),
    .ae_flag_i(ae_flag_i), .cons_done_i(cons_done_i),
    .wr_en_n_o(wr_en_n_o), .window_o(window_o), .burst_req_o(burst_req_o),
    .rd_en_o(rd_en_o), .blk_rdy_o(blk_rdy_o)
  );

  // Window vectors: {sync, tick, expected write enable after the edge}
  localparam logic [2:0] WTAB [18] = '{
    3'b001, // idle
    3'b011, // R5 tick while closed ignored
    3'b100, // R3 rising sync opens
    3'b110, // held sync, tick 1
    3'b000,
    3'b110, // R4 rise while open ignored, tick 2
    3'b010, // tick 3
    3'b000,
    3'b011, // R5 tick 4 closes
    3'b001,
    3'b100, // R3 reopen
    3'b010, 3'b010, 3'b010,
    3'b111, // R4 rise on closing cycle ignored, closes
    3'b101, // R4 held sync does not reopen
    3'b001,
    3'b100  // R3 fresh rise opens
  };

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "wr_en_n", wr_en_n_o, 1'b1);
    chk("R1", "window", window_o, 1'b0);
    chk("R1", "rd_en", rd_en_o, 1'b0);
    chk("R1", "burst_req", burst_req_o, 1'b0);
    chk("R1", "blk_rdy", blk_rdy_o, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;

    // Window table walk (R2 R3 R4 R5)
    for (int i = 0; i < 18; i++) begin
      @(negedge clk);
      sync_i = WTAB[i][2];
      tick_i = WTAB[i][1];
      @(posedge clk);
      #1;
      chk("R2-wen", $sformatf("row %0d wr_en_n", i), wr_en_n_o, WTAB[i][0]);
      chk("R2-win", $sformatf("row %0d window", i), window_o, ~WTAB[i][0]);
    end
    @(negedge clk);
    sync_i = 1'b0;
    tick_i = 1'b0;

    // First burst: R6 R7 R8, then R9 waiting without ack
    @(negedge clk);
    ae_flag_i = 1'b1;
    for (int i = 0; i < 16; i++) begin
      @(posedge clk);
      #1;
      chk("R7", $sformatf("cyc %0d rd_en", i), rd_en_o, i < BL);
      chk("R6", $sformatf("cyc %0d burst_req", i), burst_req_o, i == 0);
      chk("R8", $sformatf("cyc %0d blk_rdy", i), blk_rdy_o, i == BL);
      if (i > BL) chk("R9", $sformatf("cyc %0d wait rd_en", i), rd_en_o, 1'b0);
    end

    // R10: ack with flag high chains straight into a new burst
    @(negedge clk);
    cons_done_i = 1'b1;
    @(posedge clk);
    #1;
    chk("R10", "chain rd_en", rd_en_o, 1'b1);
    chk("R10", "chain burst_req", burst_req_o, 1'b1);

    // Second burst with an early ack mid-burst: R9 ignores it
    for (int i = 1; i < 16; i++) begin
      @(negedge clk);
      cons_done_i = (i == 3);
      @(posedge clk);
      #1;
      chk("R7", $sformatf("b2 cyc %0d rd_en", i), rd_en_o, i < BL);
      chk("R8", $sformatf("b2 cyc %0d blk_rdy", i), blk_rdy_o, i == BL);
    end

    // R10: ack with flag low re-arms without reading
    @(negedge clk);
    ae_flag_i = 1'b0;
    cons_done_i = 1'b1;
    @(posedge clk);
    #1;
    chk("R10", "rearm rd_en", rd_en_o, 1'b0);
    @(negedge clk);
    cons_done_i = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R10", "armed idle rd_en", rd_en_o, 1'b0);

    // R6: flag rises later, burst starts on next edge
    @(negedge clk);
    ae_flag_i = 1'b1;
    @(posedge clk);
    #1;
    chk("R6", "late rd_en", rd_en_o, 1'b1);
    chk("R6", "late burst_req", burst_req_o, 1'b1);
    @(posedge clk);
    #1;
    chk("R6", "req pulse ends", burst_req_o, 1'b0);

    summary();
  end

endmodule